// File: doc/BRIEF.md
# MDIO Management Master

This block is a synchronous station-management master. It produces the management clock (MDC) from the system clock. It drives or samples the bidirectional data line so that a host can read and write PHY registers with both the short-address frame format (Clause 22) and the extended frame format (Clause 45). The host presents a transaction with a one-cycle request strobe. The block raises busy while it works, pulses done once at the end, and then presents read data and a turnaround-error flag.

An extended-format access is carried out as two frames sent back to back. The first is an address frame that carries the device address and the 16-bit register address. The second is the read or write frame. On a read, the first turnaround bit is sampled. If the PHY does not pull it low, the master clocks out a fixed flush, returns all-ones and flags the error. The data line is split into a pad output, an output enable and a pad input. Whenever the master is not driving, the output is held high so that it behaves as a pull-up.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 MDC cycles during which the master drives the data line to 1.
- R2: A Clause 22 frame sends start bits 0,1, then opcode 1,0 for a read or 0,1 for a write.
- R3: A Clause 45 access sends a complete address frame (start 0,0, opcode 0,0, device address in the register field, 16-bit register address as data), followed by a frame with start 0,0 and opcode 1,1 for a read or 0,1 for a write.
- R4: After the opcode, the 5-bit PHY address and then the 5-bit register/device address are sent, each MSB first.
- R5: A write or address frame drives turnaround 1,0, then 16 data bits MSB first, then one further MDC cycle with the line released. The frame is 65 MDC cycles long.
- R6: A read frame releases the line after the register field (bit 46 of the frame) and samples turnaround. If that bit is 0, it shifts in 16 bits MSB first, clocks one idle cycle, and returns them on rd_data with ta_err low. The frame is 64 MDC cycles long.
- R7: If the sampled turnaround bit is 1, the master clocks 32 further MDC cycles, returns 16'hFFFF and sets ta_err.
- R8: Output data and enable change only while MDC is low. MDC stays high for HALF_CYC clocks on driven bits and for RD_HI_CYC clocks on sampled bits. Input is sampled after MDC falls.
- R9: While the output enable is low, the output pin is held at 1.
- R10: A request is accepted only while busy is low. A request while busy is ignored. done is a one-cycle pulse in the cycle busy falls.
- R11: After reset, MDC=0, output enable=0, output=1, busy=0, done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transaction request strobe |
| op_rd | input | 1 | 1 = read, 0 = write |
| c45_en | input | 1 | 1 = Clause 45 access (address frame first) |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address (Clause 22) or device address (Clause 45) |
| c45_reg | input | 16 | Clause 45 register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read result, updated at done on reads |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| ta_err | output | 1 | Turnaround not driven low on the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The bench builds the block with HALF_CYC=2 and RD_HI_CYC=3, so a bit takes only a handful of system clocks. This keeps complete two-frame extended accesses and the 79-bit flush sequence short enough to capture bit by bit. Because the two values differ, the measured MDC high time on a sampled bit can be told apart from the time on a driven bit. A small PHY model keyed to the MDC edge count drives the turnaround and data bits, or leaves the line pulled high to provoke the error path.

// File: rtl/mdio_pkg.sv
// Package: shared types, frame field sizes and the header encoder for the
// management master. Assumes the standard 5-bit address fields.
package mdio_pkg;

    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 4 + PHY_W + REG_W;
    localparam int WR_BITS    = 2 + DATA_W;
    localparam int FLUSH_BITS = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_WDATA,
        PH_TAIL,
        PH_RTA,
        PH_RDATA,
        PH_FLUSH
    } phase_t;

    // Builds start, opcode, PHY and register fields, MSB sent first.
    function automatic logic [HDR_BITS-1:0] hdr_word(
        input logic             addr_frm,
        input logic             c45,
        input logic             rd,
        input logic [PHY_W-1:0] phy,
        input logic [REG_W-1:0] rg
    );
        logic [1:0] st;
        logic [1:0] op;
        if (c45) begin
            st = 2'b00;
            op = addr_frm ? 2'b00 : (rd ? 2'b11 : 2'b01);
        end else begin
            st = 2'b01;
            op = rd ? 2'b10 : 2'b01;
        end
        return {st, op, phy, rg};
    endfunction

endpackage

// File: rtl/mdio_bit_engine.sv
// Bit engine: runs one MDC period per go pulse. On a driven bit it sets the
// pad output while MDC is low, holds MDC low HALF_CYC clocks, then high
// HALF_CYC clocks. On a released bit MDC stays high RD_HI_CYC clocks, and
// the input is offered in the END cycle that follows the falling edge.
// Assumes go arrives only while the engine is idle or ending a bit.
module mdio_bit_engine #(
    parameter int HALF_CYC  = 32,
    parameter int RD_HI_CYC = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic drive,
    input  logic tx_bit,
    input  logic mdio_i,
    output logic bit_done,
    output logic rx_bit,
    output logic mdc,
    output logic mdo,
    output logic oe
);
    localparam int LIM_MAX = (HALF_CYC > RD_HI_CYC) ? HALF_CYC : RD_HI_CYC;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] LOW_END = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] HI_WR   = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] HI_RD   = CNT_W'(RD_HI_CYC - 1);

    typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH, B_END} bst_t;

    bst_t             st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_end;

    // Bit timing state machine and pad registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= B_IDLE;
            cnt    <= '0;
            hi_end <= HI_WR;
            mdc    <= 1'b0;
            mdo    <= 1'b1;
            oe     <= 1'b0;
        end else begin
            case (st)
                B_IDLE, B_END: begin
                    if (go) begin
                        oe     <= drive;
                        mdo    <= drive ? tx_bit : 1'b1;
                        hi_end <= drive ? HI_WR : HI_RD;
                        cnt    <= '0;
                        st     <= B_LOW;
                    end else begin
                        st <= B_IDLE;
                    end
                end
                B_LOW: begin
                    if (cnt == LOW_END) begin
                        cnt <= '0;
                        mdc <= 1'b1;
                        st  <= B_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == hi_end) begin
                        cnt <= '0;
                        mdc <= 1'b0;
                        st  <= B_END;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign bit_done = (st == B_END);
    assign rx_bit   = mdio_i;

    AST_PAD_STABLE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdo) && $stable(oe))); // R8
    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> mdo); // R9
    AST_SAMPLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> !mdc); // R8
    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !mdc); // R8

endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: accepts a host request, then walks preamble, header,
// write data or read capture, tail and flush phases one bit at a time
// through the bit engine. A Clause 45 request runs an address frame first.
// Assumes bit_done is a one-cycle pulse per completed MDC period.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              op_rd,
    input  logic              c45_en,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] c45_reg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bit_done,
    input  logic              rx_bit,
    output logic              go,
    output logic              drive,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              ta_err
);
    localparam int SH_W  = WR_BITS;
    localparam int CNT_W = $clog2(PRE_BITS + 1);

    phase_t            phase;
    logic [CNT_W-1:0]  cnt;
    logic [SH_W-1:0]   tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic              rd_q, c45_q, addr_frm, err;
    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  rg_q;
    logic [DATA_W-1:0] creg_q, wd_q;

    // Current bit request presented to the bit engine.
    always_comb begin
        drive  = (phase == PH_PRE) || (phase == PH_HDR) || (phase == PH_WDATA);
        tx_bit = (phase == PH_PRE) ? 1'b1 : tx_sh[SH_W-1];
    end

    // Phase sequencing, shift registers and host handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rd_q     <= 1'b0;
            c45_q    <= 1'b0;
            addr_frm <= 1'b0;
            err      <= 1'b0;
            phy_q    <= '0;
            rg_q     <= '0;
            creg_q   <= '0;
            wd_q     <= '0;
            go       <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            ta_err   <= 1'b0;
            rd_data  <= '0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (req) begin
                    rd_q     <= op_rd;
                    c45_q    <= c45_en;
                    addr_frm <= c45_en;
                    phy_q    <= phy_addr;
                    rg_q     <= reg_addr;
                    creg_q   <= c45_reg;
                    wd_q     <= wdata;
                    err      <= 1'b0;
                    busy     <= 1'b1;
                    cnt      <= '0;
                    phase    <= PH_PRE;
                    go       <= 1'b1;
                end
            end else if (bit_done) begin
                go  <= 1'b1;
                cnt <= cnt + 1'b1;
                case (phase)
                    PH_PRE: begin
                        if (cnt == CNT_W'(PRE_BITS - 1)) begin
                            cnt   <= '0;
                            tx_sh <= {hdr_word(addr_frm, c45_q, rd_q, phy_q, rg_q),
                                      {(SH_W - HDR_BITS){1'b0}}};
                            phase <= PH_HDR;
                        end
                    end
                    PH_HDR: begin
                        tx_sh <= {tx_sh[SH_W-2:0], 1'b0};
                        if (cnt == CNT_W'(HDR_BITS - 1)) begin
                            cnt <= '0;
                            if (!addr_frm && rd_q) begin
                                phase <= PH_RTA;
                            end else begin
                                tx_sh <= {2'b10, (addr_frm ? creg_q : wd_q)};
                                phase <= PH_WDATA;
                            end
                        end
                    end
                    PH_WDATA: begin
                        tx_sh <= {tx_sh[SH_W-2:0], 1'b0};
                        if (cnt == CNT_W'(WR_BITS - 1)) begin
                            cnt   <= '0;
                            phase <= PH_TAIL;
                        end
                    end
                    PH_RTA: begin
                        cnt <= '0;
                        if (rx_bit) begin
                            err   <= 1'b1;
                            phase <= PH_FLUSH;
                        end else begin
                            phase <= PH_RDATA;
                        end
                    end
                    PH_RDATA: begin
                        rx_sh <= {rx_sh[DATA_W-2:0], rx_bit};
                        if (cnt == CNT_W'(DATA_W - 1)) begin
                            cnt   <= '0;
                            phase <= PH_TAIL;
                        end
                    end
                    PH_FLUSH: begin
                        if (cnt == CNT_W'(FLUSH_BITS - 1)) begin
                            go      <= 1'b0;
                            cnt     <= '0;
                            phase   <= PH_IDLE;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            ta_err  <= 1'b1;
                            rd_data <= '1;
                        end
                    end
                    default: begin
                        cnt <= '0;
                        if (addr_frm) begin
                            addr_frm <= 1'b0;
                            phase    <= PH_PRE;
                        end else begin
                            go      <= 1'b0;
                            phase   <= PH_IDLE;
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            ta_err  <= err;
                            if (rd_q) rd_data <= rx_sh;
                        end
                    end
                endcase
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_done) |=> busy); // R10
    AST_FLUSH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ta_err) |-> (rd_q && rd_data == 16'hFFFF)); // R7

endmodule

// File: rtl/mdio_master.sv
// Top level of the management master: connects the frame sequencer to the
// bit engine and exposes host and pad signals. The pad tri-state cell is
// outside; mdio_o is held high whenever mdio_oe is low.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYC  = 32,
    parameter int RD_HI_CYC = 44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              op_rd,
    input  logic              c45_en,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] c45_reg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              ta_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic go, drive, tx_bit, bit_done, rx_bit;

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .op_rd    (op_rd),
        .c45_en   (c45_en),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .c45_reg  (c45_reg),
        .wdata    (wdata),
        .bit_done (bit_done),
        .rx_bit   (rx_bit),
        .go       (go),
        .drive    (drive),
        .tx_bit   (tx_bit),
        .rd_data  (rd_data),
        .busy     (busy),
        .done     (done),
        .ta_err   (ta_err)
    );

    mdio_bit_engine #(
        .HALF_CYC  (HALF_CYC),
        .RD_HI_CYC (RD_HI_CYC)
    ) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .drive    (drive),
        .tx_bit   (tx_bit),
        .mdio_i   (mdio_i),
        .bit_done (bit_done),
        .rx_bit   (rx_bit),
        .mdc      (mdc),
        .mdo      (mdio_o),
        .oe       (mdio_oe)
    );

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (!mdio_oe && !mdc)); // R11

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int HALF = 2;
    localparam int RDHI = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, op_rd = 1'b0, c45_en = 1'b0;
    logic [4:0]  phy_addr = '0, reg_addr = '0;
    logic [15:0] c45_reg = '0, wdata = '0;
    logic [15:0] rd_data;
    logic        busy, done, ta_err, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0, n_bad = 0;

    // Capture of each MDC period and PHY response model.
    logic cap_d [0:255];
    logic cap_e [0:255];
    int   hi_len [0:255];
    int   cap_n = 0;
    int   hcnt = 0;
    int   rd_base = -1;
    bit   ta_ok = 1'b1;
    logic [15:0] resp = '0;

    mdio_master #(.HALF_CYC(HALF), .RD_HI_CYC(RDHI)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .op_rd(op_rd), .c45_en(c45_en),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .c45_reg(c45_reg), .wdata(wdata),
        .rd_data(rd_data), .busy(busy), .done(done), .ta_err(ta_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    always @(posedge mdc) begin
        if (rst_n) begin
            if (cap_n < 256) begin
                cap_d[cap_n] = mdio_o;
                cap_e[cap_n] = mdio_oe;
            end
            mdio_i = 1'b1;
            if (rd_base >= 0 && ta_ok) begin
                if (cap_n == rd_base + 46) mdio_i = 1'b0;
                else if (cap_n >= rd_base + 47 && cap_n <= rd_base + 62)
                    mdio_i = resp[15 - (cap_n - rd_base - 47)];
            end
            cap_n = cap_n + 1;
        end
    end

    always @(negedge clk) begin
        if (mdc) hcnt = hcnt + 1;
        else if (hcnt > 0) begin
            if (cap_n > 0 && cap_n <= 256) hi_len[cap_n-1] = hcnt;
            hcnt = 0;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    // Checks one captured frame starting at bit index base.
    task automatic chk_frame(input int base, input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] pa, input logic [4:0] ra, input bit wr,
                             input logic [15:0] d, input string srq);
        int bad;
        logic [3:0]  so;
        logic [9:0]  fld;
        logic [17:0] w;
        bit          eall;
        bad = 0;
        for (int i = 0; i < 32; i++)
            if (!(cap_e[base+i] === 1'b1 && cap_d[base+i] === 1'b1)) bad++;
        chk(bad == 0, "R1", "preamble wrong bits", bad, 0);
        eall = 1'b1; so = '0; fld = '0;
        for (int i = 0; i < 4; i++) begin
            so = {so[2:0], cap_d[base+32+i]};
            eall &= (cap_e[base+32+i] === 1'b1);
        end
        for (int i = 0; i < 10; i++) begin
            fld = {fld[8:0], cap_d[base+36+i]};
            eall &= (cap_e[base+36+i] === 1'b1);
        end
        chk(so === {st, op} && eall, srq, "start/opcode", so, {st, op});
        chk(fld === {pa, ra}, "R4", "phy/reg fields", fld, {pa, ra});
        if (wr) begin
            w = '0; eall = 1'b1;
            for (int i = 0; i < 18; i++) begin
                w = {w[16:0], cap_d[base+46+i]};
                eall &= (cap_e[base+46+i] === 1'b1);
            end
            chk(w === {2'b10, d} && eall, "R5", "turnaround+data", w, {2'b10, d});
            chk(cap_e[base+64] === 1'b0 && cap_d[base+64] === 1'b1, "R9",
                "tail bit released high", {cap_e[base+64], cap_d[base+64]}, 2'b01);
        end else begin
            bad = 0;
            for (int i = 46; i < 64; i++)
                if (!(cap_e[base+i] === 1'b0 && cap_d[base+i] === 1'b1)) bad++;
            chk(bad == 0, "R6", "read bits not released high", bad, 0);
        end
    endtask

    // Runs one transaction; returns the number of cycles busy was high.
    task automatic run_txn(input bit rd, input bit c45, input logic [4:0] pa,
                           input logic [4:0] ra, input logic [15:0] cr,
                           input logic [15:0] wd, input bit poke_busy);
        int t;
        cap_n = 0;
        @(negedge clk);
        op_rd = rd; c45_en = c45; phy_addr = pa; reg_addr = ra;
        c45_reg = cr; wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(busy === 1'b1, "R10", "busy after request", busy, 1);
        t = 0;
        while (done !== 1'b1 && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke_busy && t == 50) begin
                op_rd = ~rd; c45_en = ~c45; phy_addr = ~pa; reg_addr = ~ra; req = 1'b1;
            end else begin
                req = 1'b0;
            end
        end
        chk(done === 1'b1 && busy === 1'b0, "R10", "done with busy low",
            {done, busy}, 2'b10);
        @(negedge clk);
        chk(done === 1'b0, "R10", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        chk(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b1 &&
            busy === 1'b0 && done === 1'b0, "R11", "reset state",
            {mdc, mdio_oe, mdio_o, busy, done}, 5'b00100);
    endtask

    task automatic t_c22_write();
        rd_base = -1;
        run_txn(1'b0, 1'b0, 5'h13, 5'h0A, 16'h0, 16'hBEEF, 1'b0);
        chk(cap_n == 65, "R5", "c22 write clock count", cap_n, 65);
        chk_frame(0, 2'b01, 2'b01, 5'h13, 5'h0A, 1'b1, 16'hBEEF, "R2");
        chk(hi_len[0] == HALF, "R8", "driven bit high time", hi_len[0], HALF);
    endtask

    task automatic t_c22_read();
        rd_base = 0; ta_ok = 1'b1; resp = 16'hA5C3;
        run_txn(1'b1, 1'b0, 5'h01, 5'h1F, 16'h0, 16'h0, 1'b0);
        chk(cap_n == 64, "R6", "c22 read clock count", cap_n, 64);
        chk_frame(0, 2'b01, 2'b10, 5'h01, 5'h1F, 1'b0, 16'h0, "R2");
        chk(rd_data === 16'hA5C3 && ta_err === 1'b0, "R6", "read data",
            rd_data, 16'hA5C3);
        chk(hi_len[50] == RDHI, "R8", "sampled bit high time", hi_len[50], RDHI);
    endtask

    task automatic t_c45_write();
        rd_base = -1;
        run_txn(1'b0, 1'b1, 5'h05, 5'h07, 16'h1234, 16'h8001, 1'b0);
        chk(cap_n == 130, "R3", "c45 write clock count", cap_n, 130);
        chk_frame(0, 2'b00, 2'b00, 5'h05, 5'h07, 1'b1, 16'h1234, "R3");
        chk_frame(65, 2'b00, 2'b01, 5'h05, 5'h07, 1'b1, 16'h8001, "R3");
    endtask

    task automatic t_c45_read();
        rd_base = 65; ta_ok = 1'b1; resp = 16'h6E19;
        run_txn(1'b1, 1'b1, 5'h1C, 5'h03, 16'hFACE, 16'h0, 1'b0);
        chk(cap_n == 129, "R3", "c45 read clock count", cap_n, 129);
        chk_frame(0, 2'b00, 2'b00, 5'h1C, 5'h03, 1'b1, 16'hFACE, "R3");
        chk_frame(65, 2'b00, 2'b11, 5'h1C, 5'h03, 1'b0, 16'h0, "R3");
        chk(rd_data === 16'h6E19 && ta_err === 1'b0, "R6", "c45 read data",
            rd_data, 16'h6E19);
    endtask

    task automatic t_ta_error();
        rd_base = 0; ta_ok = 1'b0; resp = 16'h0;
        run_txn(1'b1, 1'b0, 5'h02, 5'h04, 16'h0, 16'h0, 1'b0);
        chk(cap_n == 79, "R7", "flush clock count", cap_n, 79);
        chk(rd_data === 16'hFFFF, "R7", "flush read data", rd_data, 16'hFFFF);
        chk(ta_err === 1'b1, "R7", "turnaround error flag", ta_err, 1);
        ta_ok = 1'b1;
    endtask

    task automatic t_busy_ignore();
        int n0;
        rd_base = -1;
        run_txn(1'b0, 1'b0, 5'h0C, 5'h11, 16'h0, 16'h00FF, 1'b1);
        chk(cap_n == 65, "R10", "request while busy changed frame", cap_n, 65);
        chk_frame(0, 2'b01, 2'b01, 5'h0C, 5'h11, 1'b1, 16'h00FF, "R2");
        n0 = cap_n;
        repeat (200) @(negedge clk);
        chk(busy === 1'b0 && cap_n == n0, "R10", "no second transaction",
            cap_n, n0);
        chk(ta_err === 1'b0, "R6", "write clears error flag", ta_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_c22_write();
        t_c22_read();
        t_ta_error();
        t_c45_write();
        t_c45_read();
        t_busy_ignore();
        summary_and_end();
    end
endmodule